// File: doc/BRIEF.md
# Stripe and Gradation Test Pattern Generator

This block sits on a 12-bit pixel stream. When test mode is off, the live pixel stream passes straight through. When test mode is on, the block keeps the live stream's handshake but swaps each pixel's data for a pattern that it generates itself. A downstream stage can then be checked against values that are known in advance.

There are two patterns. The stripe pattern alternates between a programmed black level and that level plus 128, and it changes every N pixels. The gradation pattern starts at 1 and counts up by one every M pixels, wrapping back to 1 after 4095. A single 2-bit interval field sets N for the stripe and M for the gradation.

A line-start pulse restarts whichever pattern is selected. The pattern moves forward only on pixels the sink actually accepts. Back-pressure is therefore transparent: a stalled pixel keeps its pattern value until it is taken.

Top module: `test_pattern_gen`

## Requirements
- R1: With `tm_enable` low, `out_data` equals `in_data` in the same cycle.
- R2: In every mode, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. A pixel is transferred in a cycle where `in_valid` and `out_ready` are both high.
- R3: With `tm_enable` high, `pat_sel` = 0 selects the gradation pattern and `pat_sel` = 1 selects the stripe pattern.
- R4: The black level is twice `black_code` (0 to 510). The stripe's two values are that black level and the black level + 128.
- R5: The stripe pattern holds each value for 8, 16, 32 or 64 pixels, for `interval_sel` = 0, 1, 2 or 3. Each line starts on the black level.
- R6: The gradation pattern holds each code for 2, 4, 8 or 16 pixels, for `interval_sel` = 0, 1, 2 or 3. Each line starts at code 1.
- R7: The gradation code goes from 4095 back to 1.
- R8: A cycle without a transfer does not advance the pattern, so a stalled pixel keeps its value.
- R9: When `line_start` is high, the pixel presented in that cycle already carries the pattern's first value.
- R10: While `tm_enable` is low, and after reset, the pattern is held at its first value. The first pixel after enabling therefore carries the first value without a line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tm_enable | input | 1 | Test mode on (1) or live pass-through (0) |
| pat_sel | input | 1 | 0 gradation, 1 stripe |
| interval_sel | input | 2 | Pattern interval code |
| black_code | input | 8 | Black level code; the level is twice this value |
| line_start | input | 1 | Restarts the pattern for a new line |
| in_valid | input | 1 | Live pixel valid |
| in_ready | output | 1 | Live pixel accepted |
| in_data | input | 12 | Live pixel data |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink ready |
| out_data | output | 12 | Output pixel data |

## Verification
The pattern value is built from the current registered state. A corrupt phase bit or gradation code therefore appears on `out_data` in the same cycle as the pixel it affects. A corrupt interval count shows up later, as a change at the wrong pixel index, at most 64 accepted pixels after the fault. The bench compares out_data at pixel indices on both sides of every interval boundary. It also compares out_data after stalls, after a restart in the middle of a line, and at the 4095 wrap. Any of these faults therefore makes a check miss by a whole pixel.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {
    PAT_GRAD   = 1'b0,
    PAT_STRIPE = 1'b1
  } pat_e;
endpackage

// File: rtl/tpg_interval_ctr.sv
module tpg_interval_ctr #(
  parameter int SEL_W       = 2,
  parameter int STRIPE_LOG2 = 3,
  parameter int RAMP_LOG2   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic             pat_sel,
  input  logic [SEL_W-1:0] interval_sel,
  output logic             step
);
  localparam int CNT_W = STRIPE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim, cnt_q, cnt_eff, cnt_d;

  always_comb begin
    span    = (CNT_W+1)'(1) << ((pat_sel ? STRIPE_LOG2 : RAMP_LOG2) + int'(interval_sel));
    lim     = CNT_W'(span - 1'b1);
    cnt_eff = restart ? '0 : cnt_q;
    step    = advance && (cnt_eff == lim);
    if (!advance)  cnt_d = cnt_eff;
    else if (step) cnt_d = '0;
    else           cnt_d = cnt_eff + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tpg_stripe_gen.sv
module tpg_stripe_gen #(
  parameter int DATA_W  = 12,
  parameter int BLACK_W = 8,
  parameter int STEP    = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               step,
  input  logic [BLACK_W-1:0] black_code,
  output logic [DATA_W-1:0]  level
);
  logic hi_q, hi_eff;
  logic [DATA_W-1:0] black;

  always_comb begin
    black  = DATA_W'({black_code, 1'b0});
    hi_eff = restart ? 1'b0 : hi_q;
    level  = hi_eff ? black + DATA_W'(STEP) : black;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 1'b0;
    else        hi_q <= step ? ~hi_eff : hi_eff;
  end
endmodule

// File: rtl/tpg_ramp_gen.sv
module tpg_ramp_gen #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [DATA_W-1:0] code
);
  localparam logic [DATA_W-1:0] FIRST = DATA_W'(1);
  localparam logic [DATA_W-1:0] LAST  = {DATA_W{1'b1}};

  logic [DATA_W-1:0] code_q, code_d;

  always_comb begin
    code = restart ? FIRST : code_q;
    if (!step)             code_d = code;
    else if (code == LAST) code_d = FIRST;
    else                   code_d = code + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= FIRST;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
  parameter int DATA_W      = 12,
  parameter int BLACK_W     = 8,
  parameter int SEL_W       = 2,
  parameter int STRIPE_LOG2 = 3,
  parameter int RAMP_LOG2   = 1,
  parameter int STRIPE_STEP = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tm_enable,
  input  logic               pat_sel,
  input  logic [SEL_W-1:0]   interval_sel,
  input  logic [BLACK_W-1:0] black_code,
  input  logic               line_start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data
);
  import tpg_pkg::*;

  logic restart, advance, step;
  logic [DATA_W-1:0] stripe_val, ramp_val;
  pat_e pat;

  assign restart   = line_start || !tm_enable;
  assign advance   = tm_enable && in_valid && out_ready;
  assign pat       = pat_e'(pat_sel);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  tpg_interval_ctr #(
    .SEL_W(SEL_W), .STRIPE_LOG2(STRIPE_LOG2), .RAMP_LOG2(RAMP_LOG2)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
    .pat_sel(pat_sel), .interval_sel(interval_sel), .step(step)
  );

  tpg_stripe_gen #(
    .DATA_W(DATA_W), .BLACK_W(BLACK_W), .STEP(STRIPE_STEP)
  ) u_stripe (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .black_code(black_code), .level(stripe_val)
  );

  tpg_ramp_gen #(
    .DATA_W(DATA_W)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step), .code(ramp_val)
  );

  always_comb begin
    if (!tm_enable)             out_data = in_data;
    else if (pat == PAT_STRIPE) out_data = stripe_val;
    else                        out_data = ramp_val;
  end
endmodule

// File: rtl/test_pattern_gen_chk.sv
module test_pattern_gen_chk #(
  parameter int DATA_W      = 12,
  parameter int BLACK_W     = 8,
  parameter int SEL_W       = 2,
  parameter int STRIPE_STEP = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tm_enable,
  input logic               pat_sel,
  input logic [SEL_W-1:0]   interval_sel,
  input logic [BLACK_W-1:0] black_code,
  input logic               line_start,
  input logic               in_valid,
  input logic               in_ready,
  input logic [DATA_W-1:0]  in_data,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data
);
  logic [DATA_W-1:0] blk;
  assign blk = DATA_W'({black_code, 1'b0});

  // R2
  handshake_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  // R1
  live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tm_enable |-> out_data == in_data);

  // R4
  stripe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_enable && pat_sel) |-> (out_data == blk || out_data == blk + DATA_W'(STRIPE_STEP)));

  // R9
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_enable && line_start && !pat_sel) |-> out_data == DATA_W'(1));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_enable && !line_start && !(in_valid && out_ready)) ##1
    (tm_enable && !line_start && $stable(pat_sel) && $stable(interval_sel) && $stable(black_code))
    |-> $stable(out_data));

  // R7
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_enable && !pat_sel && !line_start &&
     $past(tm_enable && !pat_sel && !line_start && in_valid && out_ready) &&
     out_data != $past(out_data))
    |-> (out_data == $past(out_data) + DATA_W'(1)) ||
        ($past(out_data) == {DATA_W{1'b1}} && out_data == DATA_W'(1)));
endmodule

bind test_pattern_gen test_pattern_gen_chk #(
  .DATA_W(DATA_W), .BLACK_W(BLACK_W), .SEL_W(SEL_W), .STRIPE_STEP(STRIPE_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tm_enable(tm_enable), .pat_sel(pat_sel),
  .interval_sel(interval_sel), .black_code(black_code), .line_start(line_start),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_test_pattern_gen.sv
module tb_test_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tm_enable = 1'b1, pat_sel = 1'b0, line_start = 1'b0;
  logic [1:0]  interval_sel = 2'd0;
  logic [7:0]  black_code = 8'd80;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [11:0] in_data = 12'h000;
  logic        in_ready, out_valid;
  logic [11:0] out_data;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  test_pattern_gen dut (
    .clk(clk), .rst_n(rst_n), .tm_enable(tm_enable), .pat_sel(pat_sel),
    .interval_sel(interval_sel), .black_code(black_code), .line_start(line_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // {pat_sel, interval_sel, black_code, pixel index, expected}
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'd80,  13'd0,  12'd160},  // R5 R4 line starts low
    {1'b1, 2'd0, 8'd80,  13'd7,  12'd160},  // R5
    {1'b1, 2'd0, 8'd80,  13'd8,  12'd288},  // R5
    {1'b1, 2'd0, 8'd80,  13'd16, 12'd160},  // R5
    {1'b1, 2'd1, 8'd80,  13'd15, 12'd160},  // R5
    {1'b1, 2'd1, 8'd80,  13'd16, 12'd288},  // R5
    {1'b1, 2'd2, 8'd0,   13'd31, 12'd0},    // R4
    {1'b1, 2'd2, 8'd0,   13'd32, 12'd128},  // R4
    {1'b1, 2'd3, 8'd255, 13'd63, 12'd510},  // R4
    {1'b1, 2'd3, 8'd255, 13'd64, 12'd638},  // R4
    {1'b0, 2'd0, 8'd0,   13'd0,  12'd1},    // R6 R3
    {1'b0, 2'd0, 8'd0,   13'd1,  12'd1},    // R6
    {1'b0, 2'd0, 8'd0,   13'd2,  12'd2},    // R6
    {1'b0, 2'd1, 8'd0,   13'd7,  12'd2},    // R6
    {1'b0, 2'd2, 8'd0,   13'd40, 12'd6},    // R6
    {1'b0, 2'd3, 8'd7,   13'd15, 12'd1},    // R6
    {1'b0, 2'd3, 8'd7,   13'd16, 12'd2}     // R6
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse line_start with no transfer, then stream pixels up to index idx.
  task automatic run_to(input int idx);
    @(posedge clk); #1 line_start = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); #1 line_start = 1'b0; in_valid = 1'b1;
    repeat (idx) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Reset state (R10, R2)
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset first value", out_data, 12'd1);
    check("R2 valid follows", {11'd0, out_valid}, 12'd1);
    #1 rst_n = 1'b1; in_valid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pat_sel      = VEC[i][35];
      interval_sel = VEC[i][34:33];
      black_code   = VEC[i][32:25];
      run_to(int'(VEC[i][24:12]));
      check($sformatf("R3/R4/R5/R6 vec%0d", i), out_data, VEC[i][11:0]);
      in_valid = 1'b0;
    end

    // R1: disabled pass-through
    @(posedge clk); #1 tm_enable = 1'b0; in_valid = 1'b1; in_data = 12'hABC;
    @(negedge clk);
    check("R1 pass-through", out_data, 12'hABC);
    #1 in_data = 12'h123; in_valid = 1'b0;
    @(negedge clk);
    check("R1 pass-through idle", out_data, 12'h123);
    check("R2 valid low", {11'd0, out_valid}, 12'd0);

    // R10: enable mid-stream starts at first value
    pat_sel = 1'b0; interval_sel = 2'd0;
    #1 tm_enable = 1'b1;
    run_to(7);
    check("R6 before disable", out_data, 12'd4);
    #1 tm_enable = 1'b0;
    @(posedge clk); #1 tm_enable = 1'b1;
    @(negedge clk);
    check("R10 re-enable first value", out_data, 12'd1);
    in_valid = 1'b0;

    // R8: stall keeps value
    run_to(4);
    check("R8 pre-stall", out_data, 12'd3);
    #1 out_ready = 1'b0;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R8 held during stall", out_data, 12'd3);
      check("R2 ready follows", {11'd0, in_ready}, 12'd0);
    end
    #1 out_ready = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 resumes at index 6", out_data, 12'd4);
    in_valid = 1'b0;

    // R9: restart mid-line in a transfer cycle
    run_to(10);
    check("R6 mid-line", out_data, 12'd6);
    #1 line_start = 1'b1;
    @(negedge clk);
    check("R9 restart same cycle", out_data, 12'd1);
    @(posedge clk); #1 line_start = 1'b0;
    @(negedge clk);
    check("R9 second pixel", out_data, 12'd1);
    @(posedge clk); @(negedge clk);
    check("R9 third pixel", out_data, 12'd2);
    in_valid = 1'b0;

    // R9 stripe restart lands on black level
    pat_sel = 1'b1; black_code = 8'd10;
    run_to(9);
    check("R5 high phase", out_data, 12'd148);
    #1 line_start = 1'b1;
    @(negedge clk);
    check("R9 stripe restart", out_data, 12'd20);
    @(posedge clk); #1 line_start = 1'b0; in_valid = 1'b0;

    // R7: wrap 4095 -> 1
    pat_sel = 1'b0; interval_sel = 2'd0;
    run_to(8189);
    check("R7 last code", out_data, 12'd4095);
    @(posedge clk); @(negedge clk);
    check("R7 wrap to 1", out_data, 12'd1);
    in_valid = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule